// File: doc/BRIEF.md
# Console DMA Arbitration Engine

This block arbitrates the two DMA sources of a 6502-style console that stall the CPU and take over its bus. A sprite transfer copies one 256-byte page of memory into sprite memory, one byte per read/write pair. A sample fetch reads a single byte for the audio unit, which asks for it either as a load (after it has been enabled) or as a reload (after its sample buffer runs dry). The engine runs on the CPU clock. Each cycle carries a get/put label from the `phase_get` input, and that label alone decides where alignment cycles fall.

While it owns the bus, the engine holds `halt` high and drives the address and read strobe each cycle. On cycles where it stalls but has nothing of its own to fetch, it re-reads the address the CPU left parked on the bus, because reading some registers has side effects. A sample fetch can cut into a running sprite transfer. A configuration bit selects the chip revision, which decides whether one extra parked re-read is made when the two halts coincide.

The controller has eight states. Their transitions are:

- `ST_IDLE`: the bus belongs to the CPU.
  - Goes to `ST_HALT` when a request is pending and the CPU's next cycle is a read.
  - A pending sample fetch blocks the start of a sprite transfer.
  - A pending reload also waits until the halt would land on a put cycle.
- `ST_HALT`: the CPU is stopped and the parked address is read.
  - Goes to `ST_DUMMY` if a sample fetch is pending.
  - Otherwise goes to `ST_ALIGN` if the halt was a get cycle, or to the next get slot if it was a put cycle.
- `ST_DUMMY`: a parked re-read.
  - Goes to `ST_ALIGN` on a get cycle, or to `ST_SREAD` on a put cycle.
- `ST_ALIGN`: a put cycle.
  - It re-reads the parked address only when no sprite transfer is owed.
  - Goes to the next get slot.
- `ST_REREAD`: the extra parked re-read of the revision that has it.
  - Goes to the next get slot.
- The next get slot is chosen the same way from every state that leads to it: `ST_SREAD` if a sample fetch is pending, otherwise `ST_OREAD`.
- `ST_OREAD`: reads sprite source byte n.
  - Goes to `ST_OWRITE`.
- `ST_OWRITE`: writes that byte to the sprite port.
  - Goes to `ST_IDLE` after byte 255, otherwise to the next get slot.
- `ST_SREAD`: reads the sample byte.
  - Goes to `ST_IDLE` if no sprite transfer is owed.
  - Otherwise goes to `ST_REREAD` (coincident halts with the revision bit set) or to `ST_ALIGN`.

Top module: `cpu_dma_arbiter`

## Requirements
- R1: `halt` first rises only in the cycle after a cycle in which `cpu_rd_next` was 1. A request stays pending through cycles with `cpu_rd_next` 0.
- R2: When a sample fetch and a sprite transfer are both pending, the sample byte is read before any sprite byte. No sprite read is issued in a get slot while a sample fetch is pending.
- R3: A sprite transfer alone keeps `halt` high for 513 cycles if the halt cycle is a put (`phase_get`=0), or 514 cycles if it is a get (`phase_get`=1).
  - It reads address page*256+n on get cycles, for n from 0 to 255 in order.
  - It writes that byte on the following put cycle through `spr_we`, `spr_idx`=n and `spr_wdata`.
- R4: A load sample fetch keeps `halt` high for 3 cycles when its halt cycle is a get, and 4 cycles when it is a put. The sample read happens on a get cycle.
- R5: A reload sample fetch always has its halt on a put cycle, so it lasts 4 cycles.
- R6: Stalled cycles read the parked `cpu_addr` with `bus_rd`=1. These are the halt and dummy cycles, and an alignment cycle when no sprite transfer is owed. A sample fetch alone therefore makes len-1 parked reads. A sprite transfer alone makes exactly 1.
- R7: A sample fetch that arrives during a sprite transfer takes one get slot plus one idle put cycle. The transfer resumes at the same byte index and lasts 2 cycles longer.
- R8: When both requests start together, the put cycle after the sample read is a parked re-read if `rev_extra_rd`=1, and has no bus access if it is 0. The length is the same either way: the sample length, plus 1, plus 512.
- R9: `halt` falls in the cycle right after the final sprite write or the final sample read. `smp_valid` pulses for one cycle, the cycle after the sample read, with the byte read in `smp_data`.
- R10: After reset, `halt`, `bus_rd`, `spr_we` and `smp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_next | input | 1 | CPU's next cycle is a read |
| phase_get | input | 1 | 1: current cycle is a get cycle, 0: put cycle |
| cpu_addr | input | 16 | Address parked on the bus by the CPU |
| rev_extra_rd | input | 1 | Revision select: 1 adds the coincident-halt re-read |
| spr_go | input | 1 | Strobe: start a sprite transfer |
| spr_page | input | 8 | Source page of the sprite transfer |
| smp_load | input | 1 | Strobe: load sample fetch request |
| smp_reload | input | 1 | Strobe: reload sample fetch request |
| smp_addr | input | 16 | Sample fetch address |
| bus_rdata | input | 8 | Read data from the bus |
| halt | output | 1 | CPU halted, DMA owns the bus |
| bus_addr | output | 16 | Bus address driven by the engine |
| bus_rd | output | 1 | Read strobe |
| spr_we | output | 1 | Sprite memory write strobe |
| spr_idx | output | 8 | Sprite memory byte index |
| spr_wdata | output | 8 | Sprite memory write data |
| smp_data | output | 8 | Fetched sample byte |
| smp_valid | output | 1 | One-cycle pulse: `smp_data` holds a new byte |

## Verification
The bench measures the length of every transfer against the phase of its halt cycle. This catches an engine that ignores the get/put label, inserts alignment unconditionally or mis-counts pairs; such an engine would show 513 where 514 is due. A reload placed on each parity shows whether it was treated as a load, which would give 3 instead of 4 cycles.

Counting parked-address reads exposes a design that skips the side-effect re-reads or adds spurious ones. Running the coincident case with both revision settings separates the two outcomes at equal length. A sample fetch injected mid-transfer checks that the byte index is neither skipped nor repeated. Holding off the read indication checks that no halt lands on a write cycle.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_DUMMY,
        ST_ALIGN,
        ST_REREAD,
        ST_OREAD,
        ST_OWRITE,
        ST_SREAD
    } dma_state_e;
endpackage

// File: rtl/cdma_req_track.sv
module cdma_req_track #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spr_go,
    input  logic [PAGE_W-1:0] spr_page,
    input  logic              smp_load,
    input  logic              smp_reload,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic              smp_taken,
    input  logic              spr_finished,
    output logic              smp_pend,
    output logic              smp_is_load,
    output logic [ADDR_W-1:0] smp_addr_q,
    output logic              spr_pend,
    output logic [PAGE_W-1:0] spr_page_q
);
    // Sample request: a new strobe wins over a same-cycle completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_pend    <= 1'b0;
            smp_is_load <= 1'b0;
            smp_addr_q  <= '0;
        end else if (smp_load || smp_reload) begin
            smp_pend    <= 1'b1;
            smp_is_load <= smp_load;
            smp_addr_q  <= smp_addr;
        end else if (smp_taken) begin
            smp_pend    <= 1'b0;
        end
    end

    // Sprite request: a start strobe during a running transfer is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spr_pend   <= 1'b0;
            spr_page_q <= '0;
        end else if (spr_finished) begin
            spr_pend   <= 1'b0;
        end else if (spr_go && !spr_pend) begin
            spr_pend   <= 1'b1;
            spr_page_q <= spr_page;
        end
    end
endmodule

// File: rtl/cdma_fsm.sv
module cdma_fsm
    import cdma_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int XFER_LEN = 256,
    localparam int IDX_W   = $clog2(XFER_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd_next,
    input  logic              phase_get,
    input  logic              rev_extra_rd,
    input  logic              smp_pend,
    input  logic              smp_is_load,
    input  logic              spr_pend,
    input  logic [DATA_W-1:0] bus_rdata,
    output dma_state_e        state,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] byte_buf,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_valid,
    output logic              smp_taken,
    output logic              spr_finished
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);

    dma_state_e nxt;
    dma_state_e get_slot;
    logic       dbl;
    logic       start;

    assign get_slot     = smp_pend ? ST_SREAD : ST_OREAD;
    assign smp_taken    = (state == ST_SREAD);
    assign spr_finished = (state == ST_OWRITE) && (idx == LAST_IDX);
    assign start        = (state == ST_IDLE) && (nxt == ST_HALT);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (smp_pend) begin
                    if (cpu_rd_next && (smp_is_load || phase_get))
                        nxt = ST_HALT;
                end else if (spr_pend && cpu_rd_next) begin
                    nxt = ST_HALT;
                end
            end
            ST_HALT: begin
                if (smp_pend)       nxt = ST_DUMMY;
                else if (phase_get) nxt = ST_ALIGN;
                else                nxt = get_slot;
            end
            ST_DUMMY:  nxt = phase_get ? ST_ALIGN : ST_SREAD;
            ST_ALIGN:  nxt = get_slot;
            ST_REREAD: nxt = get_slot;
            ST_OREAD:  nxt = ST_OWRITE;
            ST_OWRITE: nxt = (idx == LAST_IDX) ? ST_IDLE : get_slot;
            ST_SREAD: begin
                if (!spr_pend)                 nxt = ST_IDLE;
                else if (rev_extra_rd && dbl)  nxt = ST_REREAD;
                else                           nxt = ST_ALIGN;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            byte_buf  <= '0;
            smp_data  <= '0;
            smp_valid <= 1'b0;
            dbl       <= 1'b0;
        end else begin
            smp_valid <= (state == ST_SREAD);
            if (state == ST_SREAD) begin
                smp_data <= bus_rdata;
                dbl      <= 1'b0;
            end
            if (start) dbl <= smp_pend && spr_pend;
            if (state == ST_IDLE)  idx <= '0;
            if (state == ST_OWRITE) idx <= idx + 1'b1;
            if (state == ST_OREAD) byte_buf <= bus_rdata;
        end
    end

    assert_halt_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) == ST_IDLE) |-> $past(cpu_rd_next));

    assert_sample_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OREAD) |-> !$past(smp_pend));

    assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWRITE) |-> $past(state) == ST_OREAD);

    assert_sample_on_get_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SREAD) |-> phase_get);

    assert_reload_put_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) == ST_IDLE && $past(smp_pend) && !smp_is_load)
        |-> !phase_get);
endmodule

// File: rtl/cdma_bus_drive.sv
module cdma_bus_drive
    import cdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dma_state_e        state,
    input  logic              phase_get,
    input  logic              spr_pend,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] smp_addr_q,
    input  logic [PAGE_W-1:0] spr_page_q,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] byte_buf,
    output logic              halt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              spr_we,
    output logic [IDX_W-1:0]  spr_idx,
    output logic [DATA_W-1:0] spr_wdata
);
    logic [ADDR_W-1:0] spr_src;
    assign spr_src = {spr_page_q, idx};

    always_comb begin
        halt      = (state != ST_IDLE);
        bus_addr  = cpu_addr;
        bus_rd    = 1'b0;
        spr_we    = 1'b0;
        spr_idx   = idx;
        spr_wdata = byte_buf;
        unique case (state)
            ST_IDLE:   bus_rd = 1'b0;
            ST_HALT:   bus_rd = 1'b1;
            ST_DUMMY:  bus_rd = 1'b1;
            ST_REREAD: bus_rd = 1'b1;
            ST_ALIGN:  bus_rd = !spr_pend;
            ST_OREAD: begin
                bus_addr = spr_src;
                bus_rd   = 1'b1;
            end
            ST_OWRITE: begin
                bus_addr = spr_src;
                spr_we   = 1'b1;
            end
            ST_SREAD: begin
                bus_addr = smp_addr_q;
                bus_rd   = 1'b1;
            end
            default: bus_rd = 1'b0;
        endcase
    end

    assert_write_on_put_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spr_we |-> !phase_get);

    assert_parked_reread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT || state == ST_DUMMY) |-> (bus_rd && bus_addr == cpu_addr));

    assert_halt_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt) |-> ($past(state) == ST_OWRITE || $past(state) == ST_SREAD));
endmodule

// File: rtl/cpu_dma_arbiter.sv
module cpu_dma_arbiter
    import cdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int XFER_LEN = 256,
    localparam int IDX_W   = $clog2(XFER_LEN),
    localparam int PAGE_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd_next,
    input  logic              phase_get,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              rev_extra_rd,
    input  logic              spr_go,
    input  logic [PAGE_W-1:0] spr_page,
    input  logic              smp_load,
    input  logic              smp_reload,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              halt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              spr_we,
    output logic [IDX_W-1:0]  spr_idx,
    output logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_valid
);
    logic              smp_pend, smp_is_load, spr_pend;
    logic              smp_taken, spr_finished;
    logic [ADDR_W-1:0] smp_addr_q;
    logic [PAGE_W-1:0] spr_page_q;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] byte_buf;
    dma_state_e        state;

    cdma_req_track #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .spr_go(spr_go), .spr_page(spr_page),
        .smp_load(smp_load), .smp_reload(smp_reload), .smp_addr(smp_addr),
        .smp_taken(smp_taken), .spr_finished(spr_finished),
        .smp_pend(smp_pend), .smp_is_load(smp_is_load), .smp_addr_q(smp_addr_q),
        .spr_pend(spr_pend), .spr_page_q(spr_page_q)
    );

    cdma_fsm #(.DATA_W(DATA_W), .XFER_LEN(XFER_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_next(cpu_rd_next), .phase_get(phase_get), .rev_extra_rd(rev_extra_rd),
        .smp_pend(smp_pend), .smp_is_load(smp_is_load), .spr_pend(spr_pend),
        .bus_rdata(bus_rdata),
        .state(state), .idx(idx), .byte_buf(byte_buf),
        .smp_data(smp_data), .smp_valid(smp_valid),
        .smp_taken(smp_taken), .spr_finished(spr_finished)
    );

    cdma_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .state(state), .phase_get(phase_get), .spr_pend(spr_pend),
        .cpu_addr(cpu_addr), .smp_addr_q(smp_addr_q), .spr_page_q(spr_page_q),
        .idx(idx), .byte_buf(byte_buf),
        .halt(halt), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .spr_we(spr_we), .spr_idx(spr_idx), .spr_wdata(spr_wdata)
    );
endmodule

// File: tb/cpu_dma_arbiter_bench.sv
module cpu_dma_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PARK = 16'hC123;
    localparam logic [15:0] SADR = 16'hE0F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd_next = 1'b1;
    logic        phase_get = 1'b0;
    logic [15:0] cpu_addr = PARK;
    logic        rev_extra_rd = 1'b0;
    logic        spr_go = 1'b0;
    logic [7:0]  spr_page = 8'h00;
    logic        smp_load = 1'b0;
    logic        smp_reload = 1'b0;
    logic [15:0] smp_addr = SADR;
    logic [7:0]  bus_rdata;
    logic        halt, bus_rd, spr_we, smp_valid;
    logic [15:0] bus_addr;
    logic [7:0]  spr_idx, spr_wdata, smp_data;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    assign bus_rdata = mem_f(bus_addr);

    cpu_dma_arbiter u_cpu_dma_arbiter (
        .clk(clk), .rst_n(rst_n), .cpu_rd_next(cpu_rd_next), .phase_get(phase_get),
        .cpu_addr(cpu_addr), .rev_extra_rd(rev_extra_rd), .spr_go(spr_go),
        .spr_page(spr_page), .smp_load(smp_load), .smp_reload(smp_reload),
        .smp_addr(smp_addr), .bus_rdata(bus_rdata), .halt(halt), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .spr_we(spr_we), .spr_idx(spr_idx), .spr_wdata(spr_wdata),
        .smp_data(smp_data), .smp_valid(smp_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int errs = 0;
    int checks = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        if (rst_n) phase_get = ~phase_get;
    end

    // Monitor state
    logic [7:0] cur_page = 8'h00;
    logic prev_halt = 1'b0;
    int x_start, x_len, x_park, x_wr, x_end, x_first_we;
    logic x_ph;
    int exp_idx, last_we_cyc, s_rd_cyc, done_cnt, n_valid, wr_bad, val_bad;
    initial begin
        x_start = 0; x_len = 0; x_park = 0; x_wr = 0; x_end = 0; x_first_we = 0;
        x_ph = 1'b0; exp_idx = 0; last_we_cyc = 0; s_rd_cyc = -10;
        done_cnt = 0; n_valid = 0; wr_bad = 0; val_bad = 0;
    end

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (halt && !prev_halt) begin
                x_start = cyc; x_ph = phase_get; x_len = 0; x_park = 0;
                x_wr = 0; exp_idx = 0; x_first_we = 0;
            end
            if (halt) begin
                x_len = x_len + 1;
                if (bus_rd && bus_addr == cpu_addr) x_park = x_park + 1;
                if (bus_rd && bus_addr == smp_addr) s_rd_cyc = cyc;
            end
            if (spr_we) begin
                if (exp_idx == 0) x_first_we = cyc;
                if (spr_idx != exp_idx[7:0] || spr_wdata != mem_f({cur_page, spr_idx}) || phase_get)
                    wr_bad = wr_bad + 1;
                exp_idx = exp_idx + 1;
                x_wr = x_wr + 1;
                last_we_cyc = cyc;
            end
            if (smp_valid) begin
                n_valid = n_valid + 1;
                if (smp_data != mem_f(smp_addr) || cyc != s_rd_cyc + 1) val_bad = val_bad + 1;
            end
            if (!halt && prev_halt) begin
                x_end = cyc;
                done_cnt = done_cnt + 1;
            end
            prev_halt = halt;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errs = errs + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic align_phase(input logic want);
        @(negedge clk);
        while (phase_get != want) @(negedge clk);
    endtask

    task automatic wait_done(input int d0);
        wait (done_cnt == d0 + 1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #2;
        check("R10 halt", halt, 0);
        check("R10 bus_rd", bus_rd, 0);
        check("R10 spr_we", spr_we, 0);
        check("R10 smp_valid", smp_valid, 0);
    endtask

    task automatic t_sprite(input logic [7:0] page, input logic ph);
        int d0 = done_cnt;
        int bad0 = wr_bad;
        cur_page = page;
        align_phase(ph);
        spr_page = page; spr_go = 1'b1;
        @(negedge clk); spr_go = 1'b0;
        wait_done(d0);
        check("R3 halt phase", x_ph, ph);
        check("R3 length", x_len, ph ? 514 : 513);
        check("R3 writes", x_wr, 256);
        check("R3 write data/order", wr_bad - bad0, 0);
        check("R9 release after last write", x_end, last_we_cyc + 1);
        check("R6 sprite parked reads", x_park, 1);
    endtask

    task automatic t_sample(input logic is_load, input logic ph);
        int d0 = done_cnt;
        int v0 = n_valid;
        int vb0 = val_bad;
        int exp_len;
        align_phase(ph);
        if (is_load) smp_load = 1'b1; else smp_reload = 1'b1;
        @(negedge clk); smp_load = 1'b0; smp_reload = 1'b0;
        wait_done(d0);
        if (is_load) begin
            exp_len = ph ? 3 : 4;
            check("R4 load length", x_len, exp_len);
        end else begin
            exp_len = 4;
            check("R5 reload halt on put", x_ph, 0);
            check("R5 reload length", x_len, exp_len);
        end
        check("R6 sample parked reads", x_park, exp_len - 1);
        check("R9 valid pulse", n_valid - v0, 1);
        check("R9 valid data/timing", val_bad - vb0, 0);
        check("R9 release after sample read", x_end, s_rd_cyc + 1);
    endtask

    task automatic t_wait_read();
        int d0 = done_cnt;
        int k;
        int early = 0;
        cpu_rd_next = 1'b0;
        @(negedge clk); smp_load = 1'b1;
        @(negedge clk); smp_load = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #2;
            if (halt) early = early + 1;
        end
        check("R1 no halt on writes", early, 0);
        @(negedge clk); cpu_rd_next = 1'b1; k = cyc;
        wait_done(d0);
        check("R1 halt follows read cycle", x_start, k + 1);
    endtask

    task automatic t_interleave();
        int d0 = done_cnt;
        int bad0 = wr_bad;
        int v0 = n_valid;
        cur_page = 8'h37;
        align_phase(1'b0);
        spr_page = 8'h37; spr_go = 1'b1;
        @(negedge clk); spr_go = 1'b0;
        wait (x_wr == 20);
        @(negedge clk); smp_load = 1'b1;
        @(negedge clk); smp_load = 1'b0;
        wait_done(d0);
        check("R7 lengthened by 2", x_len, 515);
        check("R7 writes", x_wr, 256);
        check("R7 index resumes", wr_bad - bad0, 0);
        check("R7 sample delivered", n_valid - v0, 1);
        check("R7 parked reads", x_park, 1);
    endtask

    task automatic t_coincide(input logic rev, input logic ph);
        int d0 = done_cnt;
        int bad0 = wr_bad;
        rev_extra_rd = rev;
        cur_page = 8'hA4;
        align_phase(ph);
        spr_page = 8'hA4; spr_go = 1'b1; smp_load = 1'b1;
        @(negedge clk); spr_go = 1'b0; smp_load = 1'b0;
        wait_done(d0);
        check("R8 length", x_len, (ph ? 3 : 4) + 1 + 512);
        check("R8 parked reads by revision", x_park, rev ? 3 : 2);
        check("R2 sample before sprite", (s_rd_cyc < x_first_we) ? 1 : 0, 1);
        check("R8 writes", x_wr - (wr_bad - bad0), 256);
        rev_extra_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_sprite(8'h02, 1'b0);
        t_sprite(8'h5C, 1'b1);
        t_sample(1'b1, 1'b1);
        t_sample(1'b1, 1'b0);
        t_sample(1'b0, 1'b0);
        t_sample(1'b0, 1'b1);
        t_wait_read();
        t_interleave();
        t_coincide(1'b1, 1'b1);
        t_coincide(1'b0, 1'b1);
        t_coincide(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs = errs + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule